// File: doc/BRIEF.md
# Bus Access Abort Classifier

This block watches every access a processor issues onto its system bus and decides whether the access must be refused. Each request carries an address, a flag that tells an instruction fetch apart from a data access, and a write strobe. The block looks the address up in a fixed map. The map holds code flash, a special-register window, on-chip RAM, a boot ROM, two peripheral buses cut into 16 KB slots, and the unimplemented gaps between them. One cycle later it reports the matched region and raises either a data abort or a prefetch abort. For peripheral hits it also reports the slot index and the masked in-slot offset.

Whether an access is legal depends on both the region and the kind of access. Gaps and unassigned peripheral slots refuse every access. Instruction fetches are refused from all peripheral space and from the special-register window. Data writes are refused in code flash. A data access to an undefined offset inside an assigned slot is accepted. The slot sees only a parameterised number of low address bits, so such an access lands on an aliased register.

Top module: `bus_abort_classifier`

## Requirements
- R1: While reset is asserted, and afterwards until the first request, rsp_valid, data_abort and prefetch_abort are 0. Asserting rst_n clears them at once, even if a response is in flight.
- R2: rsp_valid is 1 exactly in the cycle after a cycle with req_valid high. When rsp_valid is 0, both abort outputs are 0.
- R3: region encodes the match as follows: 0 gap, 1 flash 0x00000000–0x0007FFFF, 2 special registers 0x3FFF8000–0x3FFFFFFF, 3 RAM 0x40000000–0x4000FFFF, 4 boot ROM 0x7FFFE000–0x7FFFFFFF, 5 low peripheral bus 0xE0000000–0xE01FFFFF, 6 high peripheral bus 0xFFE00000–0xFFFFFFFF.
- R4: Any access to a gap (region 0) aborts. This covers external memory at 0x80000000–0xDFFFFFFF.
- R5: Any access to a peripheral slot whose bit is clear in the assigned-slot mask aborts. By default, slots 0–15 of the low bus are assigned except slot 5, and slots 0 and 127 of the high bus are assigned.
- R6: An instruction fetch from any peripheral slot raises prefetch_abort, even when the slot is assigned.
- R7: An instruction fetch from the special-register window raises prefetch_abort. Data reads and writes there are legal.
- R8: A data write to flash raises data_abort. Data reads and instruction fetches from flash are legal.
- R9: A data access to an assigned slot does not abort. slot_idx is address bits [20:14], and slot_offset is address bits [OFF_BITS-1:0] (default 12). For example, 0xE000D000 and 0xE000C000 give the same index 3 and offset 0.
- R10: An abort is reported as data_abort for data accesses and as prefetch_abort for fetches, never both. The write strobe has no effect on a fetch.
- R11: RAM and boot ROM accept every access kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access present this cycle |
| req_addr | input | 32 | Access address |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_write | input | 1 | Data write strobe |
| rsp_valid | output | 1 | Classification result valid |
| data_abort | output | 1 | Data access refused |
| prefetch_abort | output | 1 | Instruction fetch refused |
| region | output | 4 | Matched region code |
| slot_idx | output | 7 | Peripheral slot index, 0 outside peripheral space |
| slot_offset | output | 12 | Masked offset inside the slot, 0 outside peripheral space |

## Verification
On every cycle the assertions check four things: the one-cycle response timing, that the two abort kinds exclude each other, that every gap response aborts, and that RAM and boot ROM never abort. They also check the flash-write and special-register-fetch rules against the request registered the cycle before. Only the bench scenarios show three further behaviours. The first is the exact region boundaries, tested one word on either side. The second is the effect of the assigned-slot mask. The third is that two distinct addresses in one slot alias to the same masked offset.

// File: rtl/abt_pkg.sv
package abt_pkg;

  typedef enum logic [3:0] {
    RG_GAP   = 4'd0,
    RG_FLASH = 4'd1,
    RG_SFR   = 4'd2,
    RG_RAM   = 4'd3,
    RG_BROM  = 4'd4,
    RG_LPB   = 4'd5,
    RG_HPB   = 4'd6
  } region_e;

  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] lo,
                                     input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/abt_rst_sync.sv
module abt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/abt_region_dec.sv
module abt_region_dec
  import abt_pkg::*;
#(
  parameter logic [31:0] FLASH_LO = 32'h0000_0000,
  parameter logic [31:0] FLASH_HI = 32'h0007_FFFF,
  parameter logic [31:0] SFR_LO   = 32'h3FFF_8000,
  parameter logic [31:0] SFR_HI   = 32'h3FFF_FFFF,
  parameter logic [31:0] RAM_LO   = 32'h4000_0000,
  parameter logic [31:0] RAM_HI   = 32'h4000_FFFF,
  parameter logic [31:0] BROM_LO  = 32'h7FFF_E000,
  parameter logic [31:0] BROM_HI  = 32'h7FFF_FFFF,
  parameter logic [31:0] LPB_BASE = 32'hE000_0000,
  parameter logic [31:0] HPB_BASE = 32'hFFE0_0000,
  parameter int          SPAN_BITS = 21
) (
  input  logic [31:0] addr,
  output region_e     region
);

  localparam logic [31:0] SPAN_LAST = (32'd1 << SPAN_BITS) - 32'd1;
  localparam logic [31:0] LPB_HI    = LPB_BASE + SPAN_LAST;
  localparam logic [31:0] HPB_HI    = HPB_BASE + SPAN_LAST;

  logic hit_flash, hit_sfr, hit_ram, hit_brom, hit_lpb, hit_hpb;

  always_comb begin
    hit_flash = in_window(addr, FLASH_LO, FLASH_HI);
    hit_sfr   = in_window(addr, SFR_LO, SFR_HI);
    hit_ram   = in_window(addr, RAM_LO, RAM_HI);
    hit_brom  = in_window(addr, BROM_LO, BROM_HI);
    hit_lpb   = in_window(addr, LPB_BASE, LPB_HI);
    hit_hpb   = in_window(addr, HPB_BASE, HPB_HI);
  end

  always_comb begin
    region = RG_GAP;
    if (hit_flash)     region = RG_FLASH;
    else if (hit_sfr)  region = RG_SFR;
    else if (hit_ram)  region = RG_RAM;
    else if (hit_brom) region = RG_BROM;
    else if (hit_lpb)  region = RG_LPB;
    else if (hit_hpb)  region = RG_HPB;
  end

endmodule

// File: rtl/abt_slot_dec.sv
module abt_slot_dec #(
  parameter int SPAN_BITS = 21,
  parameter int SLOT_BITS = 14,
  parameter int OFF_BITS  = 12,
  parameter logic [(2**(SPAN_BITS-SLOT_BITS))-1:0] ASSIGNED = '0
) (
  input  logic [31:0]                    addr,
  output logic [SPAN_BITS-SLOT_BITS-1:0] slot_idx,
  output logic [OFF_BITS-1:0]            slot_offset,
  output logic                           slot_used
);

  localparam int IDX_W = SPAN_BITS - SLOT_BITS;

  assign slot_idx  = addr[SPAN_BITS-1:SLOT_BITS];
  assign slot_used = ASSIGNED[slot_idx];

  // The slot keeps only the offset bits it decodes; wider settings clamp to the slot.
  generate
    if (OFF_BITS <= SLOT_BITS) begin : g_mask
      assign slot_offset = addr[OFF_BITS-1:0];
    end else begin : g_clamp
      assign slot_offset = {{(OFF_BITS-SLOT_BITS){1'b0}}, addr[SLOT_BITS-1:0]};
    end
  endgenerate

  logic unused_hi;
  assign unused_hi = ^{addr[31:SPAN_BITS], IDX_W[0]};

endmodule

// File: rtl/abt_policy.sv
module abt_policy
  import abt_pkg::*;
(
  input  region_e region,
  input  logic    is_fetch,
  input  logic    is_write,
  input  logic    lpb_used,
  input  logic    hpb_used,
  output logic    data_abort,
  output logic    prefetch_abort
);

  logic refuse_any;
  logic refuse_fetch;
  logic refuse_data;

  always_comb begin
    refuse_any   = 1'b0;
    refuse_fetch = 1'b0;
    refuse_data  = 1'b0;
    unique case (region)
      RG_GAP:   refuse_any   = 1'b1;
      RG_FLASH: refuse_data  = is_write;
      RG_SFR:   refuse_fetch = 1'b1;
      RG_RAM:   refuse_any   = 1'b0;
      RG_BROM:  refuse_any   = 1'b0;
      RG_LPB: begin
        refuse_any   = !lpb_used;
        refuse_fetch = 1'b1;
      end
      RG_HPB: begin
        refuse_any   = !hpb_used;
        refuse_fetch = 1'b1;
      end
      default:  refuse_any   = 1'b1;
    endcase
  end

  always_comb begin
    prefetch_abort = is_fetch && (refuse_any || refuse_fetch);
    data_abort     = !is_fetch && (refuse_any || refuse_data);
  end

endmodule

// File: rtl/bus_abort_classifier.sv
module bus_abort_classifier
  import abt_pkg::*;
#(
  parameter int SPAN_BITS = 21,
  parameter int SLOT_BITS = 14,
  parameter int OFF_BITS  = 12,
  parameter logic [(2**(SPAN_BITS-SLOT_BITS))-1:0] LPB_ASSIGNED = {{112{1'b0}}, 16'hFFDF},
  parameter logic [(2**(SPAN_BITS-SLOT_BITS))-1:0] HPB_ASSIGNED = {1'b1, {126{1'b0}}, 1'b1}
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic [31:0]                    req_addr,
  input  logic                           req_fetch,
  input  logic                           req_write,
  output logic                           rsp_valid,
  output logic                           data_abort,
  output logic                           prefetch_abort,
  output logic [3:0]                     region,
  output logic [SPAN_BITS-SLOT_BITS-1:0] slot_idx,
  output logic [OFF_BITS-1:0]            slot_offset
);

  localparam int IDX_W = SPAN_BITS - SLOT_BITS;

  logic rst_n_sync;

  abt_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_sync)
  );

  region_e               region_c;
  logic [IDX_W-1:0]      lpb_idx, hpb_idx;
  logic [OFF_BITS-1:0]   lpb_off, hpb_off;
  logic                  lpb_used, hpb_used;
  logic                  da_c, pa_c;

  abt_region_dec #(.SPAN_BITS(SPAN_BITS)) u_region (
    .addr  (req_addr),
    .region(region_c)
  );

  abt_slot_dec #(
    .SPAN_BITS(SPAN_BITS), .SLOT_BITS(SLOT_BITS),
    .OFF_BITS(OFF_BITS),   .ASSIGNED(LPB_ASSIGNED)
  ) u_lpb (
    .addr       (req_addr),
    .slot_idx   (lpb_idx),
    .slot_offset(lpb_off),
    .slot_used  (lpb_used)
  );

  abt_slot_dec #(
    .SPAN_BITS(SPAN_BITS), .SLOT_BITS(SLOT_BITS),
    .OFF_BITS(OFF_BITS),   .ASSIGNED(HPB_ASSIGNED)
  ) u_hpb (
    .addr       (req_addr),
    .slot_idx   (hpb_idx),
    .slot_offset(hpb_off),
    .slot_used  (hpb_used)
  );

  abt_policy u_policy (
    .region        (region_c),
    .is_fetch      (req_fetch),
    .is_write      (req_write),
    .lpb_used      (lpb_used),
    .hpb_used      (hpb_used),
    .data_abort    (da_c),
    .prefetch_abort(pa_c)
  );

  // Next-state logic
  logic                rsp_d, da_d, pa_d;
  logic [3:0]          region_d, region_q;
  logic [IDX_W-1:0]    idx_d, idx_q;
  logic [OFF_BITS-1:0] off_d, off_q;
  logic                rsp_q, da_q, pa_q;
  logic                info_en;

  always_comb begin
    info_en  = req_valid;
    rsp_d    = req_valid;
    da_d     = req_valid && da_c;
    pa_d     = req_valid && pa_c;
    region_d = region_c;
    idx_d    = '0;
    off_d    = '0;
    if (region_c == RG_LPB) begin
      idx_d = lpb_idx;
      off_d = lpb_off;
    end else if (region_c == RG_HPB) begin
      idx_d = hpb_idx;
      off_d = hpb_off;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= 1'b0;
      da_q  <= 1'b0;
      pa_q  <= 1'b0;
    end else if (!rst_n_sync) begin
      rsp_q <= 1'b0;
      da_q  <= 1'b0;
      pa_q  <= 1'b0;
    end else begin
      rsp_q <= rsp_d;
      da_q  <= da_d;
      pa_q  <= pa_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      region_q <= 4'd0;
      idx_q    <= '0;
      off_q    <= '0;
    end else if (info_en) begin
      region_q <= region_d;
      idx_q    <= idx_d;
      off_q    <= off_d;
    end
  end

  assign rsp_valid      = rsp_q;
  assign data_abort     = da_q;
  assign prefetch_abort = pa_q;
  assign region         = region_q;
  assign slot_idx       = idx_q;
  assign slot_offset    = off_q;

endmodule

// File: rtl/abt_checker.sv
module abt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        req_fetch,
  input logic        req_write,
  input logic        rsp_valid,
  input logic        data_abort,
  input logic        prefetch_abort,
  input logic [3:0]  region
);

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_rsp_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_quiet_without_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!data_abort && !prefetch_abort));

  assert_one_abort_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_abort && prefetch_abort));

  assert_data_abort_only_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    data_abort |-> !$past(req_fetch));

  assert_gap_aborts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && region == 4'd0) |-> (data_abort || prefetch_abort));

  assert_ram_rom_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (region == 4'd3 || region == 4'd4)) |-> (!data_abort && !prefetch_abort));

  assert_flash_write_aborts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_addr <= 32'h0007_FFFF && req_write && !req_fetch)) |-> data_abort);

  assert_sfr_fetch_aborts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_fetch && req_addr >= 32'h3FFF_8000 && req_addr <= 32'h3FFF_FFFF))
      |-> prefetch_abort);

endmodule

bind bus_abort_classifier abt_checker u_abt_checker (
  .clk           (clk),
  .rst_n         (rst_n_sync),
  .req_valid     (req_valid),
  .req_addr      (req_addr),
  .req_fetch     (req_fetch),
  .req_write     (req_write),
  .rsp_valid     (rsp_valid),
  .data_abort    (data_abort),
  .prefetch_abort(prefetch_abort),
  .region        (region)
);

// File: tb/tb_bus_abort_classifier.sv
module tb_bus_abort_classifier;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_fetch;
  logic        req_write;
  logic        rsp_valid, data_abort, prefetch_abort;
  logic [3:0]  region;
  logic [6:0]  slot_idx;
  logic [11:0] slot_offset;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  bus_abort_classifier dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_fetch(req_fetch), .req_write(req_write), .rsp_valid(rsp_valid),
    .data_abort(data_abort), .prefetch_abort(prefetch_abort), .region(region),
    .slot_idx(slot_idx), .slot_offset(slot_offset)
  );

  // {req_no[3:0], fetch, write, addr[31:0], exp_data_abort, exp_prefetch_abort, exp_region[3:0]}
  localparam int NV = 29;
  localparam logic [43:0] VEC [NV] = '{
    {4'd8,  1'b0, 1'b0, 32'h0000_0100, 1'b0, 1'b0, 4'd1},  // R8 flash read
    {4'd8,  1'b0, 1'b1, 32'h0000_0100, 1'b1, 1'b0, 4'd1},  // R8 flash write
    {4'd8,  1'b1, 1'b0, 32'h0007_FFFC, 1'b0, 1'b0, 4'd1},  // R8 flash fetch top word
    {4'd8,  1'b0, 1'b1, 32'h0007_FFFC, 1'b1, 1'b0, 4'd1},  // R8 flash write top word
    {4'd4,  1'b0, 1'b1, 32'h0008_0000, 1'b1, 1'b0, 4'd0},  // R4 gap above flash
    {4'd4,  1'b1, 1'b0, 32'h0008_0000, 1'b0, 1'b1, 4'd0},  // R4 gap fetch
    {4'd4,  1'b1, 1'b0, 32'h3FFF_7FFC, 1'b0, 1'b1, 4'd0},  // R4 below sfr
    {4'd7,  1'b1, 1'b0, 32'h3FFF_8000, 1'b0, 1'b1, 4'd2},  // R7 sfr fetch
    {4'd7,  1'b0, 1'b1, 32'h3FFF_FFFC, 1'b0, 1'b0, 4'd2},  // R7 sfr write
    {4'd7,  1'b0, 1'b0, 32'h3FFF_8000, 1'b0, 1'b0, 4'd2},  // R7 sfr read
    {4'd11, 1'b0, 1'b0, 32'h4000_0000, 1'b0, 1'b0, 4'd3},  // R11 ram read
    {4'd11, 1'b1, 1'b0, 32'h4000_FFFC, 1'b0, 1'b0, 4'd3},  // R11 ram fetch
    {4'd11, 1'b0, 1'b1, 32'h4000_8000, 1'b0, 1'b0, 4'd3},  // R11 ram write
    {4'd4,  1'b0, 1'b1, 32'h4001_0000, 1'b1, 1'b0, 4'd0},  // R4 above ram
    {4'd11, 1'b1, 1'b0, 32'h7FFF_E000, 1'b0, 1'b0, 4'd4},  // R11 rom fetch
    {4'd4,  1'b0, 1'b0, 32'h7FFF_DFFC, 1'b1, 1'b0, 4'd0},  // R4 below rom
    {4'd4,  1'b0, 1'b0, 32'h8000_0000, 1'b1, 1'b0, 4'd0},  // R4 external memory
    {4'd4,  1'b1, 1'b0, 32'hDFFF_FFFC, 1'b0, 1'b1, 4'd0},  // R4 external fetch
    {4'd9,  1'b0, 1'b0, 32'hE000_C000, 1'b0, 1'b0, 4'd5},  // R9 assigned slot read
    {4'd6,  1'b1, 1'b0, 32'hE000_C000, 1'b0, 1'b1, 4'd5},  // R6 fetch assigned slot
    {4'd5,  1'b0, 1'b1, 32'hE001_4000, 1'b1, 1'b0, 4'd5},  // R5 unassigned slot 5 write
    {4'd5,  1'b1, 1'b0, 32'hE001_4000, 1'b0, 1'b1, 4'd5},  // R5 unassigned slot 5 fetch
    {4'd4,  1'b0, 1'b0, 32'hE020_0000, 1'b1, 1'b0, 4'd0},  // R4 above low bus
    {4'd4,  1'b0, 1'b0, 32'hFFDF_FFFC, 1'b1, 1'b0, 4'd0},  // R4 below high bus
    {4'd9,  1'b0, 1'b0, 32'hFFE0_0000, 1'b0, 1'b0, 4'd6},  // R9 high slot 0
    {4'd9,  1'b0, 1'b1, 32'hFFFF_C004, 1'b0, 1'b0, 4'd6},  // R9 high slot 127 write
    {4'd6,  1'b1, 1'b0, 32'hFFFF_FFFC, 1'b0, 1'b1, 4'd6},  // R6 fetch high slot
    {4'd5,  1'b0, 1'b0, 32'hFFE0_4000, 1'b1, 1'b0, 4'd6},  // R5 unassigned high slot 1
    {4'd10, 1'b1, 1'b1, 32'h0000_0010, 1'b0, 1'b0, 4'd1}   // R10 write strobe ignored on fetch
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic f, input logic w);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_fetch = f;
    req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    req_fetch = 1'b0;
    req_write = 1'b0;
    repeat (3) @(negedge clk);
    check({rsp_valid, data_abort, prefetch_abort} == 3'b000, "R1 in reset",
          {rsp_valid, data_abort, prefetch_abort}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({rsp_valid, data_abort, prefetch_abort} == 3'b000, "R1 after release",
          {rsp_valid, data_abort, prefetch_abort}, 0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][37:6], VEC[i][39], VEC[i][38]);
      check(rsp_valid == 1'b1, $sformatf("R2 valid vec %0d", i), rsp_valid, 1);
      check({data_abort, prefetch_abort, region} == VEC[i][5:0],
            $sformatf("R%0d vec %0d (R3 region)", VEC[i][43:40], i),
            {data_abort, prefetch_abort, region}, VEC[i][5:0]);
    end

    // R2: no response in the cycle after an idle request slot
    @(negedge clk);
    req_valid = 1'b0; req_addr = 32'h0000_0040; req_fetch = 1'b0; req_write = 1'b1;
    @(negedge clk);
    check({rsp_valid, data_abort} == 2'b00, "R2 idle ignored", {rsp_valid, data_abort}, 0);

    // R9 aliasing: undefined offset reaches same register index/offset
    issue(32'hE000_D000, 1'b0, 1'b0);
    check({data_abort, slot_idx, slot_offset} == {1'b0, 7'd3, 12'h000}, "R9 alias D000",
          {data_abort, slot_idx, slot_offset}, {1'b0, 7'd3, 12'h000});
    issue(32'hE000_C000, 1'b0, 1'b0);
    check({slot_idx, slot_offset} == {7'd3, 12'h000}, "R9 base C000",
          {slot_idx, slot_offset}, {7'd3, 12'h000});
    issue(32'hE000_C123, 1'b0, 1'b1);
    check({data_abort, slot_idx, slot_offset} == {1'b0, 7'd3, 12'h123}, "R9 offset",
          {data_abort, slot_idx, slot_offset}, {1'b0, 7'd3, 12'h123});
    issue(32'hFFFF_C7FF, 1'b0, 1'b0);
    check({data_abort, slot_idx, slot_offset} == {1'b0, 7'd127, 12'h7FF}, "R9 high slot",
          {data_abort, slot_idx, slot_offset}, {1'b0, 7'd127, 12'h7FF});
    issue(32'h4000_0000, 1'b0, 1'b0);
    check({slot_idx, slot_offset} == 19'd0, "R9 zero outside peripherals",
          {slot_idx, slot_offset}, 0);

    // R1: reset clears an aborting response in flight
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h8000_0000; req_fetch = 1'b0; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    check(data_abort == 1'b1, "R4 before reset", data_abort, 1);
    rst_n = 1'b0;
    #1;
    check({rsp_valid, data_abort, prefetch_abort} == 3'b000, "R1 async clear",
          {rsp_valid, data_abort, prefetch_abort}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({rsp_valid, data_abort, prefetch_abort} == 3'b000, "R1 quiet after reset",
          {rsp_valid, data_abort, prefetch_abort}, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule